// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath

This block is a behavioural synchronous static RAM core holding words of four byte lanes of nine bits each. It has a parameterised depth. Address, chip select and the write controls are captured on the rising clock edge. Reads leave through a datapath whose latency is set by a static mode input. In flow-through mode the word read from the array goes straight to the outputs. In pipelined mode it passes through an output register first.

The outputs carry a drive-enable flag that a pad ring or board-level bus uses as its tri-state control. A deselect command travels down the same pipeline as a read and is held for one extra cycle before the outputs go quiet. This dual-cycle deselect lets a controller insert a single idle cycle between reads without a gap on the bus. Output enable and sleep act asynchronously. While sleep is high, write commands are ignored and the array keeps its contents.

Top module: `sram_dp_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the output drive flag `q_oe` is 0.
- R2: With `pipe_mode` = 0, a read sampled at edge k drives the word at the sampled address from just after edge k (one stage of latency).
- R3: With `pipe_mode` = 1, a read sampled at edge k drives nothing new after edge k and drives the addressed word from just after edge k+1 (two stages of latency).
- R4: A cycle with `ce` = 1, `gw` = 0 and `bwe` = 1 is a write. Lane n occupies data bits [9n+8:9n] and is written from `din` only if `bsel[n]` = 1. All other lanes keep their contents.
- R5: A cycle with `ce` = 1 and `gw` = 1 writes all four lanes from `din`, whatever the values of `bwe` and `bsel`.
- R6: A cycle with `ce` = 1, `gw` = 0 and `bwe` = 0 is a read and leaves the array unchanged.
- R7: After a read, a deselect (`ce` = 0) sampled at edge k keeps the last read word driven for one further cycle. If the next command is also a deselect, the outputs go quiet: after edge k+1 in flow-through mode, and after edge k+2 in pipelined mode.
- R8: `q_oe` follows a low `oe` at once, without waiting for a clock edge, and comes back when `oe` returns high.
- R9: While `sleep` = 1, `q_oe` is 0 and write commands do not change the array. The contents are retained across sleep.
- R10: A write ends read drive. The outputs are quiet after the write edge in flow-through mode, and after the following edge in pipelined mode.
- R11: With `ce` = 0 no write takes place, even if `gw` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| pipe_mode | input | 1 | Static read-path select: 0 flow-through, 1 pipelined |
| ce | input | 1 | Chip enable, sampled; 0 is a deselect command |
| addr | input | ADDR_W | Word address, sampled |
| gw | input | 1 | Global write: all lanes |
| bwe | input | 1 | Byte-write enable |
| bsel | input | 4 | Per-lane select for byte writes |
| din | input | 36 | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| q_out | output | 36 | Read data |
| q_oe | output | 1 | Drive enable for the tri-state outputs |

## Verification
The bench builds the core with `ADDR_W` = 4, a sixteen-word array, so that every address can be written and read back in both read-path modes. That size also allows every one of the sixteen byte-select patterns to be tried against its own word. Expected words come from a bench-side model that applies the lane rules arithmetically. Deselect, write and sleep sequences are timed edge by edge in each mode, which covers the single-stage and two-stage latencies and the held cycle of the dual-cycle deselect.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_dp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce,
  input  logic             gw,
  input  logic             bwe,
  input  logic [LANES-1:0] bsel,
  input  logic             sleep,
  output cmd_e             cmd,
  output logic [LANES-1:0] wr_lanes
);

  // Lanes a write command touches: global write wins over byte selects.
  function automatic logic [LANES-1:0] lanes_of(input logic g, input logic b,
                                                input logic [LANES-1:0] sel);
    logic [LANES-1:0] m;
    if (g)      m = '1;
    else if (b) m = sel;
    else        m = '0;
    return m;
  endfunction

  always_comb begin
    if (!ce)            cmd = CMD_DESEL;
    else if (gw || bwe) cmd = CMD_WRITE;
    else                cmd = CMD_READ;
  end

  assign wr_lanes = (cmd == CMD_WRITE && !sleep) ? lanes_of(gw, bwe, bsel) : '0;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // Start bit of a lane inside the word.
  function automatic int lane_lsb(input int n);
    return n * LANE_W;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) store[wr_addr] <= wr_data[lane_lsb(g) +: LANE_W];
    end

    assign rd_data[lane_lsb(g) +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/sram_read_path.sv
module sram_read_path
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] arr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              oe,
  input  logic              sleep,
  output logic [WORD_W-1:0] q_out,
  output logic              q_oe
);

  // Stage A: captured command and address, array read is asynchronous.
  logic              a_vld;
  logic              a_ds;
  logic [ADDR_W-1:0] a_addr;
  // Stage B: output register used only in pipelined mode.
  logic              b_vld;
  logic [WORD_W-1:0] b_data;
  logic              data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_ds   <= 1'b0;
      a_addr <= '0;
      b_vld  <= 1'b0;
      b_data <= '0;
    end else begin
      a_ds <= (cmd == CMD_DESEL);
      unique case (cmd)
        CMD_READ: begin
          a_vld  <= 1'b1;
          a_addr <= addr;
        end
        CMD_WRITE: a_vld <= 1'b0;
        default:   if (a_ds) a_vld <= 1'b0;  // second deselect in a row
      endcase
      b_vld <= a_vld;
      if (a_vld) b_data <= arr_data;
    end
  end

  assign rd_addr = a_addr;
  assign data_ok = pipe_mode ? b_vld : a_vld;
  assign q_out   = pipe_mode ? b_data : arr_data;
  assign q_oe    = data_ok && oe && !sleep;

endmodule

// File: rtl/sram_dp_core.sv
module sram_dp_core
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    ce,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gw,
  input  logic                    bwe,
  input  logic [LANES-1:0]        bsel,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] q_out,
  output logic                    q_oe
);

  localparam int WORD_W = LANES * LANE_W;

  cmd_e              cmd;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] arr_data;

  // Named command events for the checker.
  logic cmd_is_read;
  logic cmd_is_write;
  logic cmd_is_desel;

  assign cmd_is_read  = (cmd == CMD_READ);
  assign cmd_is_write = (cmd == CMD_WRITE);
  assign cmd_is_desel = (cmd == CMD_DESEL);

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .ce       (ce),
    .gw       (gw),
    .bwe      (bwe),
    .bsel     (bsel),
    .sleep    (sleep),
    .cmd      (cmd),
    .wr_lanes (wr_lanes)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .wr_addr  (addr),
    .wr_data  (din),
    .rd_addr  (rd_addr),
    .rd_data  (arr_data)
  );

  sram_read_path #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .cmd       (cmd),
    .addr      (addr),
    .arr_data  (arr_data),
    .rd_addr   (rd_addr),
    .oe        (oe),
    .sleep     (sleep),
    .q_out     (q_out),
    .q_oe      (q_oe)
  );

endmodule

// File: rtl/sram_dp_core_chk.sv
module sram_dp_core_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              oe,
  input logic              sleep,
  input logic [WORD_W-1:0] q_out,
  input logic              q_oe,
  input logic              cmd_is_read,
  input logic              cmd_is_write,
  input logic              cmd_is_desel
);

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> oe) else $error("drive without oe");  // R8

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_oe) else $error("drive in sleep");  // R9

  AST_FLOW_READ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(rst_n) && $past(cmd_is_read) && oe && !sleep) |-> q_oe)
    else $error("flow read not driven");  // R2

  AST_PIPE_READ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(rst_n) && $past(rst_n, 2) && $past(cmd_is_read, 2) && oe && !sleep)
    |-> q_oe) else $error("pipelined read not driven");  // R3

  AST_FLOW_DCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(cmd_is_desel) && $past(cmd_is_desel, 2)) |-> !q_oe)
    else $error("flow deselect still driving");  // R7

  AST_PIPE_DCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(cmd_is_desel, 2) && $past(cmd_is_desel, 3)) |-> !q_oe)
    else $error("pipelined deselect still driving");  // R7

  AST_FLOW_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(rst_n, 2) && $past(cmd_is_desel) && $past(cmd_is_read, 2))
    |-> $stable(q_out)) else $error("held word changed");  // R7

  AST_FLOW_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(cmd_is_write)) |-> !q_oe)
    else $error("flow drive after write");  // R10

  AST_PIPE_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(cmd_is_write, 2)) |-> !q_oe)
    else $error("pipelined drive after write");  // R10

endmodule

bind sram_dp_core sram_dp_core_chk u_chk (.*);

// File: tb/sram_dp_core_bench.sv
`timescale 1ns/1ps
module sram_dp_core_bench;

  localparam int AW = 4;
  localparam int NW = 1 << AW;
  localparam int W  = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pipe_mode;
  logic          ce, gw, bwe, oe, sleep;
  logic [AW-1:0] addr;
  logic [3:0]    bsel;
  logic [W-1:0]  din;
  logic [W-1:0]  q_out;
  logic          q_oe;

  logic [W-1:0]  model [NW];
  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sram_dp_core #(.ADDR_W(AW)) u_sram_dp_core (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce(ce), .addr(addr),
    .gw(gw), .bwe(bwe), .bsel(bsel), .din(din), .oe(oe), .sleep(sleep),
    .q_out(q_out), .q_oe(q_oe)
  );

  function automatic logic [W-1:0] pat(input int x);
    return W'((64'(x) + 64'd1) * 64'h0000_0013_579B_DF1D);
  endfunction

  // Bench-side lane model: lane i spans bits [9i+8:9i].
  task automatic model_write(input int a, input logic g, input logic b,
                             input logic [3:0] m, input logic [W-1:0] d);
    for (int i = 0; i < 4; i++)
      if (g || (b && m[i])) model[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_desel();
    ce = 1'b0; gw = 1'b0; bwe = 1'b0; bsel = '0;
  endtask

  task automatic set_read(input int a);
    ce = 1'b1; gw = 1'b0; bwe = 1'b0; bsel = '0; addr = AW'(a);
  endtask

  task automatic set_wr(input int a, input logic g, input logic b,
                        input logic [3:0] m, input logic [W-1:0] d);
    ce = 1'b1; gw = g; bwe = b; bsel = m; addr = AW'(a); din = d;
  endtask

  // Read one word and compare it in the cycle the mode delivers it.
  task automatic read_back(input int a, input string req);
    set_read(a);
    step();
    if (pipe_mode) begin set_desel(); step(); end
    check(req, W'(q_oe), W'(1));
    check(req, q_out, model[a]);
    set_desel();
    repeat (3) step();
  endtask

  task automatic run_mode(input logic m);
    pipe_mode = m;
    oe = 1'b1; sleep = 1'b0; din = '0; addr = '0;
    set_desel();
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 in reset", W'(q_oe), W'(0));
    rst_n = 1'b1;
    step();
    check("R1 after reset", W'(q_oe), W'(0));

    // Fill every word with a global write.
    for (int a = 0; a < NW; a++) begin
      set_wr(a, 1'b1, 1'b0, 4'h0, pat(a + 32 * int'(m)));
      step();
      model_write(a, 1'b1, 1'b0, 4'h0, pat(a + 32 * int'(m)));
    end
    set_desel();
    repeat (3) step();

    // Back-to-back read sweep; R6 reads leave the array intact.
    for (int a = 0; a < NW; a++) begin
      set_read(a);
      step();
      if (!m) begin
        check("R2 drive", W'(q_oe), W'(1));
        check("R2 data", q_out, model[a]);
      end else if (a == 0) begin
        check("R3 not yet", W'(q_oe), W'(0));
      end else begin
        check("R3 drive", W'(q_oe), W'(1));
        check("R3 data", q_out, model[a-1]);
      end
    end
    if (m) begin
      set_desel();
      step();
      check("R3 last", q_out, model[NW-1]);
    end
    set_desel();
    repeat (3) step();
    read_back(3, "R6 reread");

    // Every byte-select pattern, each on its own word.
    for (int k = 0; k < 16; k++) begin
      set_wr(k, 1'b0, 1'b1, 4'(k), ~pat(k + 100));
      step();
      model_write(k, 1'b0, 1'b1, 4'(k), ~pat(k + 100));
      set_desel();
      step();
      read_back(k, "R4 byte lanes");
    end

    // Global write overrides byte controls.
    set_wr(5, 1'b1, 1'b1, 4'h0, pat(200));
    step();
    model_write(5, 1'b1, 1'b0, 4'h0, pat(200));
    set_desel(); step();
    read_back(5, "R5 gw bsel=0");
    set_wr(6, 1'b1, 1'b0, 4'h5, pat(201));
    step();
    model_write(6, 1'b1, 1'b0, 4'h0, pat(201));
    set_desel(); step();
    read_back(6, "R5 gw bwe=0");

    // Deselected global write is no write.
    ce = 1'b0; gw = 1'b1; addr = AW'(2); din = pat(300);
    step();
    set_desel(); step();
    read_back(2, "R11 ce low");

    // Dual-cycle deselect.
    set_read(9);
    step();
    set_desel();
    step();
    check("R7 hold drive", W'(q_oe), W'(1));
    check("R7 hold data", q_out, model[9]);
    step();
    if (m) begin
      check("R7 pipe second", W'(q_oe), W'(1));
      check("R7 pipe data", q_out, model[9]);
      step();
    end
    check("R7 off", W'(q_oe), W'(0));
    repeat (2) step();

    // Asynchronous output enable.
    set_read(4);
    step();
    if (m) begin set_desel(); step(); end
    oe = 1'b0;
    #1;
    check("R8 oe low", W'(q_oe), W'(0));
    oe = 1'b1;
    #1;
    check("R8 oe back", W'(q_oe), W'(1));
    set_desel();
    repeat (3) step();

    // A write ends read drive.
    set_read(4);
    step();
    set_wr(4, 1'b1, 1'b0, 4'h0, pat(400));
    step();
    model_write(4, 1'b1, 1'b0, 4'h0, pat(400));
    if (m) begin set_desel(); step(); end
    check("R10 write off", W'(q_oe), W'(0));
    set_desel();
    repeat (2) step();
    read_back(4, "R10 written");

    // Sleep: quiet outputs, writes ignored, contents kept.
    set_read(6);
    step();
    if (m) begin set_desel(); step(); end
    sleep = 1'b1;
    #1;
    check("R9 sleep quiet", W'(q_oe), W'(0));
    set_wr(6, 1'b1, 1'b0, 4'h0, pat(500));
    step();
    set_wr(7, 1'b0, 1'b1, 4'hF, pat(501));
    step();
    set_desel();
    step();
    sleep = 1'b0;
    step();
    read_back(6, "R9 retained");
    read_back(7, "R9 retained");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    step();
    run_mode(1'b0);
    run_mode(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule